// File: doc/BRIEF.md
# AHB Slave to Strobe/Acknowledge Bridge

This block sits behind one AHB slave select and turns each single transfer into a handshake on a small local register port. In a transfer's address phase it registers the address and the direction. In the first data-phase cycle it captures write data from the bus. From the next cycle it raises a strobe to the local logic and holds it until the local logic acknowledges. Throughout the data phase it holds its ready output low, so the master sees one wait state for each cycle the local side needs.

The local port is a stream-style request channel. `lb_strobe` acts as valid and `lb_ack` acts as ready. While the strobe is high without an acknowledge, address, direction and write data stay frozen. The request is consumed in the cycle where both are high, and the strobe drops on the following edge. An acknowledge seen while the strobe is low is ignored.

Bursts are handled as back-to-back single transfers. A watchdog counts strobe cycles and ends a transfer that is never acknowledged, so the bus cannot hang. Every response is OKAY, and every output has a single driver.

Top module: `ahb_lb_bridge`

## Requirements
- R1: While reset is active and right after it is released, `hreadyout` is 1, `lb_strobe` is 0 and `hresp` is 0 (OKAY).
- R2: A transfer is accepted only at a clock edge where `hsel` is 1, `htrans` is NONSEQ (2'b10) or SEQ (2'b11), and `hready` is 1. IDLE (2'b00) and BUSY (2'b01) transfers, and cycles where `hsel` or `hready` is low, never raise `lb_strobe`, and `hreadyout` stays 1.
- R3: The address and `hwrite` captured at the accepting edge appear on `lb_addr` and `lb_we` for the whole strobe of that transfer.
- R4: For a write, the data on `hwdata` in the first data-phase cycle is stored, and it drives `lb_wdata` while the strobe is high. `lb_strobe` rises at the edge that ends the first data-phase cycle.
- R5: `hreadyout` is 0 from the first data-phase cycle up to the cycle in which `lb_strobe` and `lb_ack` are both 1, and in that cycle it is 1. With an acknowledge after k strobe cycles without one, the transfer has k+1 wait states.
- R6: While `lb_strobe` is 1 and `lb_ack` is 0, `lb_addr`, `lb_we` and `lb_wdata` hold their values. After the acknowledge cycle, `lb_strobe` is 0.
- R7: In the completing cycle of an acknowledged read, `hrdata` equals `lb_rdata`. In every other cycle, `hrdata` is 0.
- R8: If no acknowledge arrives, the transfer completes in the TIMEOUT_CYC-th strobe cycle with `hreadyout` 1, OKAY and `hrdata` 0. The strobe then drops, so the local side records nothing for that write.
- R9: A transfer whose address phase is accepted in another transfer's completing cycle starts its data phase on the next cycle, with no idle cycle in between. SEQ is handled exactly like NONSEQ.
- R10: `hresp` is 0 (OKAY) at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | AW | Transfer address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| hwdata | input | DW | Write data (data phase) |
| hready | input | 1 | Bus ready (previous transfer done) |
| hreadyout | output | 1 | This slave's ready; low inserts wait states |
| hresp | output | 1 | Response, always OKAY |
| hrdata | output | DW | Read data |
| lb_addr | output | AW | Local address |
| lb_strobe | output | 1 | Local request valid |
| lb_we | output | 1 | Local write enable (1 = write) |
| lb_wdata | output | DW | Local write data |
| lb_rdata | input | DW | Local read data, valid with acknowledge |
| lb_ack | input | 1 | Local acknowledge (ready) |

## Verification
The bench targets wait-state accounting: each address implies a local acknowledge latency, and the bench checks the exact wait count. A design that completes one cycle early, or adds an idle cycle between pipelined transfers, fails there. Non-transfers are driven directly: IDLE and BUSY types, a deselected slave, and a stalled bus. Accepting any of them would raise a spurious strobe. Writes to a region that never acknowledges must end at the watchdog limit with zero read data. Read-back of the same word then shows that a design which let the write land, or which hung, is wrong. Write data is checked by read-back, which exposes data taken from the wrong cycle.

// File: rtl/ahb_lb_pkg.sv
package ahb_lb_pkg;

  typedef enum logic [1:0] {
    HT_IDLE   = 2'b00,
    HT_BUSY   = 2'b01,
    HT_NONSEQ = 2'b10,
    HT_SEQ    = 2'b11
  } htrans_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LATCH = 2'd1,
    PH_WAIT  = 2'd2
  } phase_e;

  localparam logic RESP_OKAY = 1'b0;

  function automatic logic is_transfer(input logic [1:0] t);
    return (htrans_e'(t) == HT_NONSEQ) || (htrans_e'(t) == HT_SEQ);
  endfunction

endpackage

// File: rtl/ahb_lb_addr_stage.sv
module ahb_lb_addr_stage #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] addr_in,
  input  logic          write_in,
  output logic [AW-1:0] addr_q,
  output logic          write_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
    end else if (take) begin
      addr_q  <= addr_in;
      write_q <= write_in;
    end
  end
endmodule

// File: rtl/ahb_lb_wdata_stage.sv
module ahb_lb_wdata_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= data_in;
  end
endmodule

// File: rtl/ahb_lb_watchdog.sv
module ahb_lb_watchdog #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT) + 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + CW'(1);
    else          cnt <= '0;
  end

  assign expire = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/ahb_lb_ctrl.sv
module ahb_lb_ctrl
  import ahb_lb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsel,
  input  logic [1:0] htrans,
  input  logic       hready,
  input  logic       write_q,
  input  logic       ack,
  input  logic       expire,
  output logic       take_addr,
  output logic       load_wdata,
  output logic       strobe,
  output logic       run_wd,
  output logic       ready_out,
  output logic       pass_rdata
);
  phase_e state, state_nx;
  logic   done;
  logic   free;

  assign done      = (state == PH_WAIT) && (ack || expire);
  assign free      = (state == PH_IDLE) || done;
  assign take_addr = free && hsel && hready && is_transfer(htrans);

  always_comb begin
    state_nx = state;
    unique case (state)
      PH_IDLE:  if (take_addr) state_nx = PH_LATCH;
      PH_LATCH: state_nx = PH_WAIT;
      PH_WAIT:  if (done) state_nx = take_addr ? PH_LATCH : PH_IDLE;
      default:  state_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PH_IDLE;
    else        state <= state_nx;
  end

  assign load_wdata = (state == PH_LATCH) && write_q;
  assign strobe     = (state == PH_WAIT);
  assign run_wd     = strobe;
  assign ready_out  = free;
  assign pass_rdata = (state == PH_WAIT) && ack && !write_q;
endmodule

// File: rtl/ahb_lb_bridge.sv
module ahb_lb_bridge
  import ahb_lb_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 32,
  parameter int TIMEOUT_CYC = 8
) (
  input  logic          hclk,
  input  logic          hresetn,
  input  logic          hsel,
  input  logic [AW-1:0] haddr,
  input  logic [1:0]    htrans,
  input  logic          hwrite,
  input  logic [DW-1:0] hwdata,
  input  logic          hready,
  output logic          hreadyout,
  output logic          hresp,
  output logic [DW-1:0] hrdata,
  output logic [AW-1:0] lb_addr,
  output logic          lb_strobe,
  output logic          lb_we,
  output logic [DW-1:0] lb_wdata,
  input  logic [DW-1:0] lb_rdata,
  input  logic          lb_ack
);
  logic take_addr, load_wdata, run_wd, expire, pass_rdata;

  ahb_lb_addr_stage #(.AW(AW)) u_addr (
    .clk(hclk), .rst_n(hresetn), .take(take_addr),
    .addr_in(haddr), .write_in(hwrite),
    .addr_q(lb_addr), .write_q(lb_we)
  );

  ahb_lb_wdata_stage #(.DW(DW)) u_wdata (
    .clk(hclk), .rst_n(hresetn), .load(load_wdata),
    .data_in(hwdata), .data_q(lb_wdata)
  );

  ahb_lb_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
    .clk(hclk), .rst_n(hresetn), .run(run_wd), .expire(expire)
  );

  ahb_lb_ctrl u_ctrl (
    .clk(hclk), .rst_n(hresetn), .hsel(hsel), .htrans(htrans),
    .hready(hready), .write_q(lb_we), .ack(lb_ack), .expire(expire),
    .take_addr(take_addr), .load_wdata(load_wdata), .strobe(lb_strobe),
    .run_wd(run_wd), .ready_out(hreadyout), .pass_rdata(pass_rdata)
  );

  assign hresp  = RESP_OKAY;
  assign hrdata = pass_rdata ? lb_rdata : '0;
endmodule

// File: rtl/ahb_lb_bridge_chk.sv
module ahb_lb_bridge_chk #(
  parameter int AW          = 16,
  parameter int DW          = 32,
  parameter int TIMEOUT_CYC = 8
) (
  input logic          hclk,
  input logic          hresetn,
  input logic          hsel,
  input logic [AW-1:0] haddr,
  input logic [1:0]    htrans,
  input logic          hready,
  input logic          hreadyout,
  input logic [DW-1:0] hrdata,
  input logic [AW-1:0] lb_addr,
  input logic          lb_strobe,
  input logic          lb_we,
  input logic [DW-1:0] lb_wdata,
  input logic [DW-1:0] lb_rdata,
  input logic          lb_ack
);
  localparam int RW = $clog2(TIMEOUT_CYC + 1) + 1;
  logic [RW-1:0] run_len;
  logic          acc;

  assign acc = hreadyout && hsel && hready && htrans[1];

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn)       run_len <= '0;
    else if (lb_strobe) run_len <= run_len + RW'(1);
    else                run_len <= '0;
  end

  // R2, R4: no strobe directly after a ready cycle
  a_r2_no_early_strobe: assert property (@(posedge hclk) disable iff (!hresetn)
    hreadyout |=> !lb_strobe);

  // R5: an accepted address phase is followed by a wait state
  a_r5_accept_stalls: assert property (@(posedge hclk) disable iff (!hresetn)
    acc |=> !hreadyout);

  // R5: acknowledge completes the data phase
  a_r5_ack_completes: assert property (@(posedge hclk) disable iff (!hresetn)
    (lb_strobe && lb_ack) |-> hreadyout);

  // R6: request held stable under back-pressure
  a_r6_hold_request: assert property (@(posedge hclk) disable iff (!hresetn)
    (lb_strobe && !lb_ack && !hreadyout) |=>
      (lb_strobe && $stable(lb_addr) && $stable(lb_we) && $stable(lb_wdata)));

  // R6: strobe drops after the acknowledge cycle
  a_r6_drop_after_ack: assert property (@(posedge hclk) disable iff (!hresetn)
    (lb_strobe && lb_ack) |=> !lb_strobe);

  // R3, R9: captured address reaches the local port two edges later
  a_r3_addr_capture: assert property (@(posedge hclk) disable iff (!hresetn)
    acc |=> ##1 (lb_strobe && lb_addr == $past(haddr, 2)));

  // R7: read data only on an acknowledged read
  a_r7_rdata_gated: assert property (@(posedge hclk) disable iff (!hresetn)
    !(lb_strobe && lb_ack && !lb_we) |-> (hrdata == '0));

  // R7: acknowledged read forwards local data
  a_r7_rdata_pass: assert property (@(posedge hclk) disable iff (!hresetn)
    (lb_strobe && lb_ack && !lb_we) |-> (hrdata == lb_rdata));

  // R8: strobe never outlasts the watchdog limit
  a_r8_bounded_strobe: assert property (@(posedge hclk) disable iff (!hresetn)
    lb_strobe |-> (run_len < RW'(TIMEOUT_CYC)));
endmodule

bind ahb_lb_bridge ahb_lb_bridge_chk #(.AW(AW), .DW(DW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (.*);

// File: tb/ahb_lb_bridge_bench.sv
module ahb_lb_bridge_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int TO = 8;
  localparam int NOPS = 300;

  logic          hclk = 1'b0;
  logic          hresetn = 1'b0;
  logic          hsel = 1'b0;
  logic [AW-1:0] haddr = '0;
  logic [1:0]    htrans = 2'b00;
  logic          hwrite = 1'b0;
  logic [DW-1:0] hwdata = '0;
  logic          stall = 1'b0;
  logic          hready;
  logic          hreadyout, hresp;
  logic [DW-1:0] hrdata;
  logic [AW-1:0] lb_addr;
  logic          lb_strobe, lb_we;
  logic [DW-1:0] lb_wdata, lb_rdata;
  logic          lb_ack;

  int total = 0;
  int bad = 0;
  int hold_err = 0;

  always #2.5 hclk = ~hclk;
  assign hready = hreadyout & ~stall;

  ahb_lb_bridge #(.AW(AW), .DW(DW), .TIMEOUT_CYC(TO)) u_ahb_lb_bridge (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
    .htrans(htrans), .hwrite(hwrite), .hwdata(hwdata), .hready(hready),
    .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
    .lb_addr(lb_addr), .lb_strobe(lb_strobe), .lb_we(lb_we),
    .lb_wdata(lb_wdata), .lb_rdata(lb_rdata), .lb_ack(lb_ack)
  );

  // Local responder: latency from address bits 7:6, bit 15 never acknowledges
  logic [DW-1:0] mem [16];
  logic [3:0]    rcnt;
  assign lb_ack   = lb_strobe && !lb_addr[15] && (rcnt == {2'b00, lb_addr[7:6]});
  assign lb_rdata = lb_ack ? mem[lb_addr[5:2]] : 32'hDEAD_BEEF;

  always @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      rcnt <= '0;
      for (int k = 0; k < 16; k++) mem[k] <= '0;
    end else begin
      rcnt <= lb_strobe ? rcnt + 4'd1 : 4'd0;
      if (lb_ack && lb_we) mem[lb_addr[5:2]] <= lb_wdata;
    end
  end

  // R6 monitor: request held while waiting
  logic          h_valid = 1'b0;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_wd;
  logic          h_we;
  always @(negedge hclk) begin
    #2;
    if (h_valid && lb_strobe &&
        (lb_addr != h_addr || lb_wdata != h_wd || lb_we != h_we))
      hold_err++;
    h_valid = lb_strobe && !lb_ack;
    h_addr  = lb_addr;
    h_wd    = lb_wdata;
    h_we    = lb_we;
  end

  // Bench model
  logic [DW-1:0] shadow [16];
  logic          op_wr  [NOPS];
  logic [AW-1:0] op_addr[NOPS];
  logic [DW-1:0] op_data[NOPS];
  logic          op_seq [NOPS];
  int            nops;

  function automatic int exp_waits(input logic [AW-1:0] a);
    return a[15] ? TO : 1 + int'(a[7:6]);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_ops();
    logic          p_valid = 1'b0;
    logic          p_wr = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_data = '0;
    for (int i = 0; i <= nops; i++) begin
      if (i < nops) begin
        hsel = 1'b1; haddr = op_addr[i]; hwrite = op_wr[i];
        htrans = op_seq[i] ? 2'b11 : 2'b10;
      end else begin
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0;
      end
      hwdata = (p_valid && p_wr) ? p_data : DW'($urandom);
      begin
        int waits = 0;
        #1;
        while (!hreadyout && waits < 50) begin
          @(posedge hclk); @(negedge hclk); #1; waits++;
        end
        if (p_valid) begin
          // R5, R8, R9: exact wait states per transfer
          chk(waits == exp_waits(p_addr), "R5/R8/R9 wait states",
              DW'(waits), DW'(exp_waits(p_addr)));
          chk(hresp == 1'b0, "R10 okay", DW'(hresp), 0);
          if (!p_wr) begin
            logic [DW-1:0] e;
            e = p_addr[15] ? '0 : shadow[p_addr[5:2]];
            chk(hrdata == e, "R7 read data (R3/R4 path)", hrdata, e);
          end else if (!p_addr[15]) begin
            shadow[p_addr[5:2]] = p_data;
          end
        end
      end
      @(posedge hclk); @(negedge hclk);
      if (i < nops) begin
        p_valid = 1'b1; p_wr = op_wr[i]; p_addr = op_addr[i]; p_data = op_data[i];
      end
    end
  endtask

  task automatic quiet_check(input string req);
    for (int c = 0; c < 3; c++) begin
      @(posedge hclk); @(negedge hclk); #1;
      chk(hreadyout && !lb_strobe, req, {hreadyout, lb_strobe}, 2'b10);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 16; k++) shadow[k] = '0;
    repeat (3) @(negedge hclk);
    // R1 during reset
    chk(hreadyout && !lb_strobe && !hresp, "R1 reset state",
        {hreadyout, lb_strobe, hresp}, 3'b100);
    hresetn = 1'b1;
    @(negedge hclk); #1;
    chk(hreadyout && !lb_strobe && !hresp, "R1 after reset",
        {hreadyout, lb_strobe, hresp}, 3'b100);

    // R2: non-transfers
    hsel = 1'b1; haddr = 16'h0004; htrans = 2'b00; quiet_check("R2 idle");
    htrans = 2'b01; quiet_check("R2 busy");
    hsel = 1'b0; htrans = 2'b10; quiet_check("R2 deselected");
    hsel = 1'b1; stall = 1'b1; quiet_check("R2 bus stalled");
    stall = 1'b0; hsel = 1'b0; htrans = 2'b00;
    @(negedge hclk);

    // Directed: write, timed-out write to same word, read back, timed-out read
    nops = 5;
    op_wr[0] = 1; op_addr[0] = 16'h00C8; op_data[0] = 32'hA5A5_0001; op_seq[0] = 0;
    op_wr[1] = 1; op_addr[1] = 16'h8008; op_data[1] = 32'h0BAD_0BAD; op_seq[1] = 1;
    op_wr[2] = 0; op_addr[2] = 16'h0008; op_data[2] = '0;            op_seq[2] = 0;
    op_wr[3] = 0; op_addr[3] = 16'h80C8; op_data[3] = '0;            op_seq[3] = 1;
    op_wr[4] = 0; op_addr[4] = 16'h00C8; op_data[4] = '0;            op_seq[4] = 0;
    run_ops();

    // Random mix
    nops = NOPS;
    for (int i = 0; i < NOPS; i++) begin
      op_wr[i]   = $urandom_range(0, 1) == 1;
      op_addr[i] = AW'($urandom) & 16'h00FC;
      if ($urandom_range(0, 9) == 0) op_addr[i][15] = 1'b1;
      op_data[i] = DW'($urandom);
      op_seq[i]  = $urandom_range(0, 1) == 1;
    end
    run_ops();

    chk(hold_err == 0, "R6 request held under back-pressure", DW'(hold_err), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule